// File: doc/BRIEF.md
# Packed Double-Precision Compare Unit

This unit takes two packed operands. Each operand holds `LANES` IEEE-754 double-precision values, and the default is two lanes in 128 bits. The unit compares each lane pair separately under a 3-bit predicate code. For every lane it returns a 64-bit mask in the matching lane position: all ones when the predicate holds and all zeros when it does not. The predicate set covers NaNs fully. It has equal, less-than and less-or-equal, their negations, and the ordered and unordered tests. The greater-than forms are obtained by swapping the operands at the input.

Two sticky status flags sit beside the result. The invalid flag records signalling NaN inputs, and quiet NaN inputs under the predicates that signal on them. The denormal flag records any subnormal input. Both flags are the OR over all lanes and over all accepted operations. They stay set until the clear input is pulsed.

Operands enter through a valid/ready handshake, and results leave through another. A single register stage lies between the two. An input is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result is consumed when `out_valid` and `out_ready` are both high. While `out_ready` is low, the held result stays unchanged and no new input is taken. A stream therefore runs at one result per cycle when the consumer never stalls.

Top module: `pd_cmp_unit`

## Requirements
- R1: Lane k occupies bits [64k+63:64k] of `in_a`, `in_b` and `out_mask`. Each output lane is all ones or all zeros and depends only on lane k of the two operands.
- R2: Predicate codes are 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal and 7 ordered. Non-NaN values, including infinities, compare by numeric value, and +0 equals -0.
- R3: A NaN is an exponent of all ones with a nonzero fraction. If either input of a lane is a NaN, predicates 0, 1, 2 and 7 give zeros, and predicates 3, 4, 5 and 6 give ones.
- R4: `flag_invalid` is set when any lane input of an accepted operation is a signalling NaN (fraction MSB 0), whatever the predicate.
- R5: A quiet NaN (fraction MSB 1) sets `flag_invalid` only under predicates 1, 2, 5 and 6. Under predicates 0, 3, 4 and 7 it leaves the flag unchanged.
- R6: `flag_denormal` is set when any lane input of an accepted operation has a zero exponent and a nonzero fraction.
- R7: Both flags stay set until `clr_flags` is high at a clock edge, which clears them. A flag event from an operation accepted at that same edge still sets its flag.
- R8: An operation accepted at clock edge n appears on `out_mask` with `out_valid` high just after edge n.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_mask` and `out_valid` hold.
- R10: During and just after reset, `out_valid`, `out_mask` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and predicate are offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_a | input | 128 | First packed operand |
| in_b | input | 128 | Second packed operand |
| in_pred | input | 3 | Predicate code |
| out_valid | output | 1 | Result mask is held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 128 | Per-lane all-ones or all-zeros result |
| clr_flags | input | 1 | Clears both sticky flags |
| flag_invalid | output | 1 | Sticky invalid status |
| flag_denormal | output | 1 | Sticky denormal status |

## Verification
The bench sweeps every predicate over all pairs drawn from a set of special values. The set holds signed zeros, signed ones, infinities, signed subnormals, quiet and signalling NaNs. The two lanes are given the pair in opposite orders, so a lane mix-up or a swapped operand flips a mask. A comparator that treats the sign bit as an ordinary magnitude bit orders negative numbers backwards and reports +0 and -0 as unequal. A negated predicate built as "ordered and opposite" returns zeros on NaN pairs where ones are due. A too-broad quiet-NaN rule sets the invalid flag under the equality or ordered tests. The consumer stalls at random and clears land on cycles that also accept work. A lost held result, a double-issued result, or a clear that wipes a same-cycle event all show up as a mask or flag mismatch.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_UNORD = 3'd3,
    PRED_NEQ   = 3'd4,
    PRED_NLT   = 3'd5,
    PRED_NLE   = 3'd6,
    PRED_ORD   = 3'd7
  } pred_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic sub;
  } fp_class_t;
endpackage

// File: rtl/pdc_classify.sv
module pdc_classify
  import pdc_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fp_class_t            cls
);
  logic exp_ones, exp_zero, man_nz;

  always_comb begin
    exp_ones  = &val[EXP_W+MAN_W-1:MAN_W];
    exp_zero  = ~|val[EXP_W+MAN_W-1:MAN_W];
    man_nz    = |val[MAN_W-1:0];
    cls.nan   = exp_ones && man_nz;
    cls.snan  = exp_ones && man_nz && !val[MAN_W-1];
    cls.sub   = exp_zero && man_nz;
  end
endmodule

// File: rtl/pdc_magcmp.sv
module pdc_magcmp #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic                 eq,
  output logic                 lt
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-2:0] mag_a, mag_b;
  logic         sa, sb, both_zero, mag_lt, mag_gt;

  always_comb begin
    sa        = a[W-1];
    sb        = b[W-1];
    mag_a     = a[W-2:0];
    mag_b     = b[W-2:0];
    both_zero = (mag_a == '0) && (mag_b == '0);
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;
    eq        = both_zero || (a == b);
    lt        = !both_zero &&
                ((sa && !sb) || (!sa && !sb && mag_lt) || (sa && sb && mag_gt));
  end
endmodule

// File: rtl/pdc_lane.sv
module pdc_lane
  import pdc_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  pred_e                pred,
  output logic                 hit,
  output logic                 inv,
  output logic                 sub
);
  fp_class_t ca, cb;
  logic      eq, lt, unord, base, qsig;

  pdc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (.val(a), .cls(ca));
  pdc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (.val(b), .cls(cb));
  pdc_magcmp   #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (.a(a), .b(b), .eq(eq), .lt(lt));

  always_comb begin
    unord = ca.nan || cb.nan;
    unique case (pred[1:0])
      2'd0:    base = !unord && eq;
      2'd1:    base = !unord && lt;
      2'd2:    base = !unord && (lt || eq);
      default: base = unord;
    endcase
    // bit 2 of the code negates the base relation
    hit  = base ^ pred[2];
    qsig = (pred[1:0] == 2'd1) || (pred[1:0] == 2'd2);
    inv  = ca.snan || cb.snan || (qsig && unord);
    sub  = ca.sub || cb.sub;
  end
endmodule

// File: rtl/pd_cmp_unit.sv
module pd_cmp_unit
  import pdc_pkg::*;
#(
  parameter int LANES = 2,
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0]  in_a,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0]  in_b,
  input  logic [2:0]                        in_pred,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [LANES*(1+EXP_W+MAN_W)-1:0]  out_mask,
  input  logic                              clr_flags,
  output logic                              flag_invalid,
  output logic                              flag_denormal
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int DW = LANES * W;

  logic [LANES-1:0] hit, inv, sub;
  logic [DW-1:0]    nxt_mask;
  logic             fire;
  pred_e            pred;

  assign pred     = pred_e'(in_pred);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pdc_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .a   (in_a[k*W +: W]),
      .b   (in_b[k*W +: W]),
      .pred(pred),
      .hit (hit[k]),
      .inv (inv[k]),
      .sub (sub[k])
    );
    assign nxt_mask[k*W +: W] = {W{hit[k]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_mask      <= '0;
      flag_invalid  <= 1'b0;
      flag_denormal <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_mask  <= nxt_mask;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      flag_invalid  <= (flag_invalid  && !clr_flags) || (fire && |inv);
      flag_denormal <= (flag_denormal && !clr_flags) || (fire && |sub);
    end
  end
endmodule

// File: rtl/pd_cmp_unit_chk.sv
module pd_cmp_unit_chk #(
  parameter int LANES = 2,
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              in_valid,
  input logic                              in_ready,
  input logic [LANES*(1+EXP_W+MAN_W)-1:0]  in_a,
  input logic [LANES*(1+EXP_W+MAN_W)-1:0]  in_b,
  input logic [2:0]                        in_pred,
  input logic                              out_valid,
  input logic                              out_ready,
  input logic [LANES*(1+EXP_W+MAN_W)-1:0]  out_mask,
  input logic                              clr_flags,
  input logic                              flag_invalid,
  input logic                              flag_denormal
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic fire, a0_nan, a0_snan, a0_sub;
  assign fire    = in_valid && in_ready;
  assign a0_nan  = (&in_a[W-2:MAN_W]) && (|in_a[MAN_W-1:0]);
  assign a0_snan = a0_nan && !in_a[MAN_W-1];
  assign a0_sub  = (~|in_a[W-2:MAN_W]) && (|in_a[MAN_W-1:0]);

  p_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !fire) |=> (!flag_invalid && !flag_denormal));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_invalid && !clr_flags) |=> flag_invalid);

  p_ord_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_pred == 3'd7 && a0_nan) |=> (out_mask[W-1:0] == '0));

  p_snan_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && a0_snan) |=> flag_invalid);

  p_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && a0_sub) |=> flag_denormal);
endmodule

bind pd_cmp_unit pd_cmp_unit_chk #(.LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_pred(in_pred), .out_valid(out_valid),
  .out_ready(out_ready), .out_mask(out_mask), .clr_flags(clr_flags),
  .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
);

// File: tb/pd_cmp_unit_bench.sv
module pd_cmp_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic [2:0]   in_pred = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_mask;
  logic         clr_flags = 1'b0;
  logic         flag_invalid, flag_denormal;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pd_cmp_unit u_pd_cmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_mask(out_mask), .clr_flags(clr_flags),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
  );

  // ---------------- reference model ----------------
  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_snan(logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic bit is_sub(logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction
  function automatic longint key(logic [63:0] x);
    longint m;
    m = longint'({1'b0, x[62:0]});
    return x[63] ? -m : m;
  endfunction
  function automatic bit ref_hit(logic [63:0] a, logic [63:0] b, int p);
    bit u;
    longint ka, kb;
    u = is_nan(a) || is_nan(b);
    ka = key(a);
    kb = key(b);
    case (p)
      0: return !u && ka == kb;
      1: return !u && ka < kb;
      2: return !u && ka <= kb;
      3: return u;
      4: return u || ka != kb;
      5: return u || !(ka < kb);
      6: return u || !(ka <= kb);
      default: return !u;
    endcase
  endfunction
  function automatic bit ref_inv(logic [63:0] a, logic [63:0] b, int p);
    bit q;
    q = (p == 1 || p == 2 || p == 5 || p == 6);
    return is_snan(a) || is_snan(b) || (q && (is_nan(a) || is_nan(b)));
  endfunction

  logic [127:0] exp_q[$];
  string        tag_q[$];
  bit           m_inv = 0;
  bit           m_den = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      tag_q.delete();
      m_inv = 0;
      m_den = 0;
    end else begin
      bit fire, ni, nd, nanny;
      logic [127:0] em;
      fire = in_valid && in_ready;
      if (out_valid && out_ready && exp_q.size() > 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      ni = 0;
      nd = 0;
      nanny = 0;
      em = '0;
      if (fire) begin
        for (int k = 0; k < 2; k++) begin
          logic [63:0] a, b;
          a = in_a[k*64 +: 64];
          b = in_b[k*64 +: 64];
          em[k*64 +: 64] = {64{ref_hit(a, b, int'(in_pred))}};
          ni |= ref_inv(a, b, int'(in_pred));
          nd |= is_sub(a) || is_sub(b);
          nanny |= is_nan(a) || is_nan(b);
        end
        exp_q.push_back(em);
        tag_q.push_back(nanny ? "R3" : "R2");
      end
      m_inv = (m_inv && !clr_flags) || ni;
      m_den = (m_den && !clr_flags) || nd;
    end
  end

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == (exp_q.size() > 0), "R8 out_valid", 128'(out_valid), 128'(exp_q.size() > 0));
      chk(in_ready == (!out_valid || out_ready), "R9 in_ready", 128'(in_ready),
          128'(!out_valid || out_ready));
      if (out_valid && exp_q.size() > 0)
        chk(out_mask === exp_q[0], {"R1/", tag_q[0], "/R9 mask"}, out_mask, exp_q[0]);
      chk(flag_invalid == m_inv, "R4/R5/R7 flag_invalid", 128'(flag_invalid), 128'(m_inv));
      chk(flag_denormal == m_den, "R6/R7 flag_denormal", 128'(flag_denormal), 128'(m_den));
    end
  end

  always @(posedge clk) out_ready <= ($urandom % 4) != 0;

  // ---------------- stimulus ----------------
  function automatic logic [63:0] val(int i);
    case (i)
      0:  return 64'h0000_0000_0000_0000;
      1:  return 64'h8000_0000_0000_0000;
      2:  return 64'h3FF0_0000_0000_0000;
      3:  return 64'hBFF0_0000_0000_0000;
      4:  return 64'h4000_0000_0000_0000;
      5:  return 64'h7FF0_0000_0000_0000;
      6:  return 64'hFFF0_0000_0000_0000;
      7:  return 64'h0000_0000_0000_0001;
      8:  return 64'h800F_FFFF_FFFF_FFFF;
      9:  return 64'h7FF8_0000_0000_0000;
      default: return 64'hFFF0_0000_0000_0001;
    endcase
  endfunction

  task automatic send(logic [127:0] a, logic [127:0] b, int p, bit do_clr);
    in_a      = a;
    in_b      = b;
    in_pred   = 3'(p);
    in_valid  = 1'b1;
    clr_flags = do_clr;
    forever begin
      if (in_ready) begin
        @(posedge clk);
        @(negedge clk);
        clr_flags = 1'b0;
        break;
      end
      @(negedge clk);
      clr_flags = 1'b0;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 0, "R10 out_valid", 128'(out_valid), 0);
    chk(out_mask == 0, "R10 out_mask", out_mask, 0);
    chk(!flag_invalid && !flag_denormal, "R10 flags", 128'({flag_invalid, flag_denormal}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    for (int p = 0; p < 8; p++)
      for (int i = 0; i < 11; i++)
        for (int j = 0; j < 11; j++) begin
          n++;
          send({val(j), val(i)}, {val(i), val(j)}, p, (n % 13) == 0);
        end
    for (int r = 0; r < 300; r++) begin
      int i0, j0, i1, j1;
      i0 = $urandom % 11; j0 = $urandom % 11;
      i1 = $urandom % 11; j1 = $urandom % 11;
      send({val(i1), val(i0)}, {val(j1), val(j0)}, $urandom % 8, ($urandom % 7) == 0);
      if ($urandom % 5 == 0) begin
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
      end
    end
    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule